// File: doc/BRIEF.md
# TDM Time-Slot Serial Transmitter

This block places one byte per frame into a chosen position on a time-division serial line. The line's bit clock comes from outside and runs well below the system clock. The block samples that clock and the frame sync into the system clock domain and detects the edges of the bit clock there. It counts bit positions from the frame sync. When the count reaches the configured slot, it loads a byte from its source and shifts the byte out one bit per bit period.

There are two data pins, each with its own output enable. Configuration inputs set the following:
- the slot number and a bit offset within the frame;
- the frame length, in 8-bit slots;
- which bit-clock edge starts a new bit;
- optional inversion of the data;
- which end of the byte goes first;
- which pins carry the data.

The second pin can instead work as an active-low strobe for an external line driver. In that mode it goes low exactly while the byte is on the first pin. If no byte is waiting when the slot begins, the block sends all-ones, as an idle line does, and raises an underrun flag.

Top module: `tdm_slot_tx`

## Requirements
- R1: `bclk_i` and `fsync_i` pass through two synchronizer flops and one edge flop. The outputs change on the third rising edge of `clk_i` after an active bit-clock transition, and do not change at any other time while the configuration is held.
- R2: With `clk_inv_i`=0 the falling transition of `bclk_i` is the active edge. With `clk_inv_i`=1 the rising transition is the active edge. The other transition has no effect.
- R3: Suppose `fsync_i` is high when an active edge is sampled. The bit period that this edge starts is then position 0.
  - At any other active edge the position advances by one.
  - After position `frame_slots_i`*8-1 the position wraps to 0.
  - From reset until the first frame sync, neither data output is enabled.
- R4: The byte occupies positions `slot_i`*8+`bit_offset_i` through that value plus 7. The whole window must lie inside the frame.
- R5: With `msb_first_i`=1, bit 7 of the byte is sent first and bit 0 last. With `msb_first_i`=0 the order is reversed.
- R6: With `data_inv_i`=1, every bit inside the window is complemented on the data pins.
- R7: `dxa_oe_o` is 1 only inside the window, and only while `a_en_i`=1. Outside the window `dxa_o` is 1.
- R8: With `b_strobe_i`=0, `dxb_oe_o` is 1 only inside the window while `b_en_i`=1, and `dxb_o` carries the same bit as `dxa_o`.
- R9: With `b_strobe_i`=1, `dxb_oe_o` is 1 at all times, whatever `b_en_i` is. `dxb_o` is 0 inside the window and 1 outside it.
- R10: If `byte_valid_i`=1 at the active edge that starts the window, the block loads `byte_i` and pulses `byte_take_o` high for one cycle, in the same cycle that the outputs change.
- R11: If `byte_valid_i`=0 at the window start, all-ones are sent (complemented when `data_inv_i`=1) and no take pulse is issued. `underrun_o` then goes to 1 and stays there until a window starts with a byte available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | External transmit bit clock |
| fsync_i | input | 1 | Frame sync, sampled on the active edge |
| byte_i | input | 8 | Byte to send in the next window |
| byte_valid_i | input | 1 | A byte is available on `byte_i` |
| byte_take_o | output | 1 | One-cycle pulse when the byte is loaded |
| underrun_o | output | 1 | The last window started without a byte |
| frame_slots_i | input | SLOT_W+1 | Frame length in 8-bit slots (at least 1) |
| slot_i | input | SLOT_W | Slot number of the window |
| bit_offset_i | input | 3 | Bit offset added to the slot start |
| clk_inv_i | input | 1 | Selects the rising edge as the active edge |
| data_inv_i | input | 1 | Complements the transmitted bits |
| msb_first_i | input | 1 | Sends bit 7 first |
| a_en_i | input | 1 | Enables data on pin A |
| b_en_i | input | 1 | Enables data on pin B |
| b_strobe_i | input | 1 | Turns pin B into an active-low driver strobe |
| dxa_o | output | 1 | Pin A data |
| dxa_oe_o | output | 1 | Pin A output enable |
| dxb_o | output | 1 | Pin B data or strobe |
| dxb_oe_o | output | 1 | Pin B output enable |

## Verification
A position counter that is off by one moves the whole enable window, and the strobe with it, by one bit period. That shift shows at the first window after the frame sync, and also after an unsynced wrap. A wrong bit index or a missed inversion corrupts one bit of the window, which is visible within eight bit periods of the window start. A stale byte register or a stuck underrun flag shows up at the next window start, through the take pulse and the flag.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic a_en;
    logic b_en;
    logic b_strobe;
  } pin_cfg_t;
endpackage

// File: rtl/tdm_bclk_sync.sv
module tdm_bclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic clk_inv_i,
  output logic tick_o,
  output logic fsync_o
);
  logic [STAGES-1:0] bclk_sync_q;
  logic [STAGES-1:0] fs_sync_q;
  logic              bclk_prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bclk_sync_q[i] <= 1'b0;
        fs_sync_q[i]   <= 1'b0;
      end else if (i == 0) begin
        bclk_sync_q[i] <= bclk_i;
        fs_sync_q[i]   <= fsync_i;
      end else begin
        bclk_sync_q[i] <= bclk_sync_q[i-1];
        fs_sync_q[i]   <= fs_sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_prev_q <= 1'b0;
    else         bclk_prev_q <= bclk_sync_q[STAGES-1];
  end

  logic cur;
  assign cur     = bclk_sync_q[STAGES-1];
  // active edge: falling by default, rising when inverted
  assign tick_o  = clk_inv_i ? (cur & ~bclk_prev_q) : (~cur & bclk_prev_q);
  assign fsync_o = fs_sync_q[STAGES-1];
endmodule

// File: rtl/tdm_frame_pos.sv
module tdm_frame_pos #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fsync_i,
  input  logic [CNT_W-1:0] last_pos_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] next_pos_o,
  output logic             synced_o,
  output logic             next_synced_o
);
  logic [CNT_W-1:0] pos_q;
  logic             synced_q;

  always_comb begin
    if (fsync_i)                 next_pos_o = '0;
    else if (pos_q >= last_pos_i) next_pos_o = '0;
    else                         next_pos_o = pos_q + 1'b1;
  end

  assign next_synced_o = synced_q | fsync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else if (tick_i) begin
      pos_q    <= next_pos_o;
      synced_q <= next_synced_o;
    end
  end

  assign pos_o    = pos_q;
  assign synced_o = synced_q;
endmodule

// File: rtl/tdm_slot_ser.sv
module tdm_slot_ser
  import tdm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              msb_first_i,
  input  logic              data_inv_i,
  output logic              bit_o,
  output logic              take_o,
  output logic              underrun_o
);
  logic [BYTE_W-1:0] data_q;
  logic              take_q;
  logic              under_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '1;
      take_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      take_q <= load_i & byte_valid_i;
      if (load_i) begin
        data_q  <= byte_valid_i ? byte_i : '1;
        under_q <= ~byte_valid_i;
      end
    end
  end

  logic [IDX_W-1:0] sel;
  assign sel        = msb_first_i ? ~idx_i : idx_i;
  assign bit_o      = data_q[sel] ^ data_inv_i;
  assign take_o     = take_q;
  assign underrun_o = under_q;
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_take_o,
  output logic              underrun_o,
  input  logic [SLOT_W:0]   frame_slots_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [2:0]        bit_offset_i,
  input  logic              clk_inv_i,
  input  logic              data_inv_i,
  input  logic              msb_first_i,
  input  logic              a_en_i,
  input  logic              b_en_i,
  input  logic              b_strobe_i,
  output logic              dxa_o,
  output logic              dxa_oe_o,
  output logic              dxb_o,
  output logic              dxb_oe_o
);
  localparam int CNT_W = SLOT_W + IDX_W + 1;
  localparam int CMP_W = CNT_W + 1;

  logic             tick, fs_s;
  logic [CNT_W-1:0] pos, next_pos, last_pos, start;
  logic             synced, next_synced;
  logic             load, window, ser_bit;
  logic [IDX_W-1:0] idx;
  pin_cfg_t         pcfg;

  assign pcfg     = '{a_en: a_en_i, b_en: b_en_i, b_strobe: b_strobe_i};
  assign last_pos = {frame_slots_i, {IDX_W{1'b0}}} - 1'b1;
  assign start    = CNT_W'({slot_i, {IDX_W{1'b0}}}) + CNT_W'(bit_offset_i);

  tdm_bclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .bclk_i, .fsync_i, .clk_inv_i,
    .tick_o(tick), .fsync_o(fs_s)
  );

  tdm_frame_pos #(.CNT_W(CNT_W)) u_pos (
    .clk_i, .rst_ni,
    .tick_i(tick), .fsync_i(fs_s), .last_pos_i(last_pos),
    .pos_o(pos), .next_pos_o(next_pos),
    .synced_o(synced), .next_synced_o(next_synced)
  );

  assign load   = tick & next_synced & (next_pos == start);
  assign window = synced & (pos >= start) &
                  (CMP_W'(pos) < CMP_W'(start) + CMP_W'(8));
  assign idx    = pos[IDX_W-1:0] - start[IDX_W-1:0];

  tdm_slot_ser u_ser (
    .clk_i, .rst_ni,
    .load_i(load), .byte_i, .byte_valid_i,
    .idx_i(idx), .msb_first_i, .data_inv_i,
    .bit_o(ser_bit), .take_o(byte_take_o), .underrun_o
  );

  assign dxa_o    = window ? ser_bit : 1'b1;
  assign dxa_oe_o = pcfg.a_en & window;
  assign dxb_oe_o = pcfg.b_strobe | (pcfg.b_en & window);
  assign dxb_o    = pcfg.b_strobe ? ~window : dxa_o;
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick,
  input logic byte_valid_i,
  input logic byte_take_o,
  input logic underrun_o,
  input logic a_en_i,
  input logic b_strobe_i,
  input logic dxa_o,
  input logic dxa_oe_o,
  input logic dxb_o,
  input logic dxb_oe_o
);
  // R1
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable({dxa_o, dxa_oe_o}));
  // R9
  strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_strobe_i && a_en_i) |-> (dxb_oe_o && (dxb_o != dxa_oe_o)));
  // R8
  pin_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dxa_oe_o && dxb_oe_o && !b_strobe_i) |-> (dxa_o == dxb_o));
  // R10
  take_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take_o |=> !byte_take_o);
  // R10
  take_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take_o |-> ($past(tick) && $past(byte_valid_i)));
  // R11
  take_under_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take_o |-> !underrun_o);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick),
  .byte_valid_i(byte_valid_i), .byte_take_o(byte_take_o),
  .underrun_o(underrun_o), .a_en_i(a_en_i), .b_strobe_i(b_strobe_i),
  .dxa_o(dxa_o), .dxa_oe_o(dxa_oe_o), .dxb_o(dxb_o), .dxb_oe_o(dxb_oe_o)
);

// File: tb/tb_tdm_slot_tx.sv
module tb_tdm_slot_tx;
  localparam int SLOT_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bclk_i = 1'b1, fsync_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic byte_valid_i = 1'b0;
  logic byte_take_o, underrun_o;
  logic [SLOT_W:0] frame_slots_i = 6'd4;
  logic [SLOT_W-1:0] slot_i = '0;
  logic [2:0] bit_offset_i = '0;
  logic clk_inv_i = 1'b0, data_inv_i = 1'b0, msb_first_i = 1'b0;
  logic a_en_i = 1'b0, b_en_i = 1'b0, b_strobe_i = 1'b0;
  logic dxa_o, dxa_oe_o, dxb_o, dxb_oe_o;

  int n_chk = 0, n_err = 0, take_cnt = 0;

  always #4 clk = ~clk;

  tdm_slot_tx #(.SLOT_W(SLOT_W)) dut (
    .clk_i(clk), .rst_ni, .bclk_i, .fsync_i, .byte_i, .byte_valid_i,
    .byte_take_o, .underrun_o, .frame_slots_i, .slot_i, .bit_offset_i,
    .clk_inv_i, .data_inv_i, .msb_first_i, .a_en_i, .b_en_i, .b_strobe_i,
    .dxa_o, .dxa_oe_o, .dxb_o, .dxb_oe_o
  );

  always @(posedge clk) if (rst_ni && byte_take_o) take_cnt++;

  // slot, offset, clk_inv, data_inv, msb_first, a_en, b_en, b_strobe, byte
  localparam logic [21:0] VECS [6] = '{
    {5'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5},
    {5'd1, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C},
    {5'd2, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81},
    {5'd2, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A},
    {5'd0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3},
    {5'd2, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0F}
  };

  task automatic check(string req, logic act, logic exp, int p);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s pos %0d: got %b expected %b", req, p, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bit_period(logic fs);
    @(negedge clk);
    bclk_i  = clk_inv_i ? 1'b0 : 1'b1;
    fsync_i = fs;
    repeat (4) @(negedge clk);
    bclk_i = ~bclk_i;
    repeat (4) @(negedge clk);
    fsync_i = 1'b0;
  endtask

  task automatic apply_vec(logic [21:0] v);
    @(negedge clk);
    slot_i       = v[21:17];
    bit_offset_i = v[16:14];
    clk_inv_i    = v[13];
    data_inv_i   = v[12];
    msb_first_i  = v[11];
    a_en_i       = v[10];
    b_en_i       = v[9];
    b_strobe_i   = v[8];
    byte_i       = v[7:0];
  endtask

  // one frame, every position checked against the requirement model
  task automatic run_frame(int nbits, logic fs_first, logic [7:0] sent);
    int start;
    start = int'(slot_i) * 8 + int'(bit_offset_i);
    for (int p = 0; p < nbits; p++) begin
      logic win, d;
      int k;
      bit_period(fs_first && p == 0);
      win = (p >= start) && (p < start + 8);
      k = p - start;
      d = win ? ((msb_first_i ? sent[7 - (k & 7)] : sent[k & 7]) ^ data_inv_i) : 1'b1;
      check("R4 R5 R6 dxa_o", dxa_o, d, p);
      check("R7 dxa_oe_o", dxa_oe_o, a_en_i & win, p);
      if (b_strobe_i) begin
        check("R9 dxb_oe_o", dxb_oe_o, 1'b1, p);
        check("R9 dxb_o", dxb_o, ~win, p);
      end else begin
        check("R8 dxb_oe_o", dxb_oe_o, b_en_i & win, p);
        check("R8 dxb_o", dxb_o, d, p);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    a_en_i = 1'b1; b_en_i = 1'b1;
    @(negedge clk);
    // R3 reset state and no drive before first sync
    check("R3 reset dxa_oe_o", dxa_oe_o, 1'b0, 0);
    check("R3 reset dxb_oe_o", dxb_oe_o, 1'b0, 0);
    check("R10 reset byte_take_o", byte_take_o, 1'b0, 0);
    check("R11 reset underrun_o", underrun_o, 1'b0, 0);
    for (int i = 0; i < 3; i++) begin
      bit_period(1'b0);
      check("R3 unsynced dxa_oe_o", dxa_oe_o, 1'b0, i);
    end

    // R1 latency: sync slot 0 offset 0, enable appears on the third clock
    byte_i = 8'h00; byte_valid_i = 1'b1;
    @(negedge clk);
    bclk_i = 1'b1; fsync_i = 1'b1;
    repeat (4) @(negedge clk);
    bclk_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 before third edge", dxa_oe_o, 1'b0, 0);
    @(negedge clk);
    check("R1 at third edge", dxa_oe_o, 1'b1, 0);
    fsync_i = 1'b0;
    repeat (2) @(negedge clk);
    // R2 inactive transition leaves bit 0 in place
    bclk_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 inactive edge dxa_oe_o", dxa_oe_o, 1'b1, 0);
    check("R2 inactive edge dxa_o", dxa_o, 1'b0, 0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      apply_vec(VECS[v]);
      base = take_cnt;
      run_frame(32, 1'b1, VECS[v][7:0]);
      check_int("R10 one take per frame", take_cnt - base, 1);
      check("R11 underrun_o low", underrun_o, 1'b0, v);
    end

    // R11 underrun: all-ones, no take, flag held
    apply_vec({5'd1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00});
    byte_valid_i = 1'b0;
    base = take_cnt;
    run_frame(32, 1'b1, 8'hFF);
    check_int("R11 no take on underrun", take_cnt - base, 0);
    check("R11 underrun_o high", underrun_o, 1'b1, 0);
    // R11 recovery with inverted data
    data_inv_i = 1'b1;
    byte_valid_i = 1'b1;
    base = take_cnt;
    run_frame(32, 1'b1, 8'h00);
    check_int("R10 take after underrun", take_cnt - base, 1);
    check("R11 underrun_o cleared", underrun_o, 1'b0, 0);

    // R3 two-slot frame, second frame runs on counter wrap only
    apply_vec({5'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h96});
    frame_slots_i = 6'd2;
    base = take_cnt;
    run_frame(16, 1'b1, 8'h96);
    run_frame(16, 1'b0, 8'h96);
    check_int("R3 wrap reloads slot", take_cnt - base, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule